// File: doc/BRIEF.md
# Converter Clock Prescaler and Trigger Timer

This block sits between the peripheral clock and a sampling converter's scan sequencer. It makes no new clocks. It produces two single-cycle enable strobes in the peripheral clock domain. The source-rate strobe comes from a programmable divide-by-(N+1) stage. The core-rate strobe comes from a second stage that passes every source strobe through or keeps only every other one. Logic downstream uses these strobes as clock enables.

A 16-bit local timer counts source-rate strobes only. When its count reaches the programmed period, it emits a one-cycle trigger event for the sequencer and starts again from zero. The prescaler settings can be loaded only while the block is disabled. The period can be loaded only while the timer is disabled. Turning the timer off clears its count. The current settings can be read back on dedicated outputs.

Top module: `convclk_top`

## Requirements
- R1: With source setting N (0 to 7), `srcTick` is high on the enabled cycles whose index k, counted from 0 at the first enabled cycle, satisfies k mod (N+1) = N. N = 0 gives a strobe on every enabled cycle.
- R2: With core setting 0, `coreTick` equals `srcTick`. With core setting 1, `coreTick` is high on the second, fourth, sixth and later source strobes after enable.
- R3: `coreTick` is never high in a cycle where `srcTick` is low.
- R4: While `blkEnable` is low, no strobe is produced and both prescaler counters return to zero, so every enable restarts the R1 and R2 sequences from their beginning.
- R5: A `cfgWr` pulse in a cycle where `blkEnable` is low loads `cfgSrcDiv` and `cfgCoreDiv`, and they appear on `srcDivSet` and `coreDivSet` from the next cycle. A `cfgWr` pulse while `blkEnable` is high changes nothing.
- R6: With period P (nonzero) and `tmrEnable` high, the timer advances only on source strobes. `tmrEvent` goes high on the source strobe that makes P strobes since the timer was enabled or since the previous event.
- R7: `tmrEvent` lasts one cycle and occurs only in a cycle where `srcTick` is high.
- R8: With period 0, `tmrEvent` is never asserted.
- R9: While `tmrEnable` is low, the timer count is held at zero. After the timer is enabled again, the next event needs a full P source strobes.
- R10: A `perWr` pulse loads `perData` into the period, visible on `periodSet` the next cycle, only when `tmrEnable` is low. While the timer is enabled, the write is ignored.
- R11: After reset, all strobes and events are low and every setting (source divisor, core divisor, period) reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blkEnable | input | 1 | Runs the prescalers; low holds them cleared and unlocks the settings |
| cfgWr | input | 1 | Write pulse for the prescaler settings |
| cfgSrcDiv | input | 3 | Source stage setting N (divide by N+1) |
| cfgCoreDiv | input | 1 | Core stage setting (0: divide by 1, 1: divide by 2) |
| tmrEnable | input | 1 | Runs the timer; low clears its count and unlocks the period |
| perWr | input | 1 | Write pulse for the period |
| perData | input | 16 | Period in source strobes |
| srcTick | output | 1 | Source-rate enable strobe |
| coreTick | output | 1 | Core-rate enable strobe |
| tmrEvent | output | 1 | Timer trigger event |
| srcDivSet | output | 3 | Current source stage setting |
| coreDivSet | output | 1 | Current core stage setting |
| periodSet | output | 16 | Current timer period |

## Verification
The strobes and the event are decoded combinationally from registered counters and the enable inputs. They are therefore due in the same cycle as the enable level that causes them. A setting or period write shows on the readback outputs one cycle after the edge that samples it. The bench drives inputs just after a rising edge and compares every output at the following falling edge against a model built from counts of enabled cycles and strobes. The model then advances its state as the coming edge will. Each comparison thus looks at exactly the cycle in which a result is due.

// File: rtl/convclk_pkg.sv
package convclk_pkg;
  // strobes from control to the timer datapath
  typedef struct packed {
    logic tmrAdv;   // count one source strobe
    logic tmrClr;   // hold count at zero
    logic perLoad;  // capture a new period
  } tmr_strobe_t;
endpackage

// File: rtl/convclk_div_stage.sv
module convclk_div_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         enIn,
  input  logic [W-1:0] divSel,
  output logic         tickOut
);
  logic [W-1:0] cnt;

  assign tickOut = enIn & (cnt == divSel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (enIn)    cnt <= tickOut ? '0 : cnt + 1'b1;
  end

  // restart from zero after any cleared cycle
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

  // phase never passes the terminal value
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= divSel);
endmodule

// File: rtl/convclk_ctrl.sv
module convclk_ctrl
  import convclk_pkg::*;
#(
  parameter int SRC_W  = 3,
  parameter int CORE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blkEnable,
  input  logic              cfgWr,
  input  logic [SRC_W-1:0]  cfgSrcDiv,
  input  logic [CORE_W-1:0] cfgCoreDiv,
  input  logic              tmrEnable,
  input  logic              perWr,
  output logic              srcTick,
  output logic              coreTick,
  output logic [SRC_W-1:0]  srcDivQ,
  output logic [CORE_W-1:0] coreDivQ,
  output tmr_strobe_t       strb
);
  logic cfgLoad;
  logic stageClr;

  assign cfgLoad  = cfgWr & ~blkEnable;
  assign stageClr = ~blkEnable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcDivQ  <= '0;
      coreDivQ <= '0;
    end else if (cfgLoad) begin
      srcDivQ  <= cfgSrcDiv;
      coreDivQ <= cfgCoreDiv;
    end
  end

  convclk_div_stage #(.W(SRC_W)) uSrc (
    .clk(clk), .rst_n(rst_n), .clear(stageClr), .enIn(blkEnable),
    .divSel(srcDivQ), .tickOut(srcTick)
  );

  convclk_div_stage #(.W(CORE_W)) uCore (
    .clk(clk), .rst_n(rst_n), .clear(stageClr), .enIn(srcTick),
    .divSel(coreDivQ), .tickOut(coreTick)
  );

  assign strb.tmrAdv  = srcTick & tmrEnable;
  assign strb.tmrClr  = ~tmrEnable;
  assign strb.perLoad = perWr & ~tmrEnable;

  // settings locked while running
  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blkEnable |=> ($stable(srcDivQ) && $stable(coreDivQ)));

  // no strobe while disabled
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stageClr) && stageClr |-> !coreTick);
endmodule

// File: rtl/convclk_timer_dp.sv
module convclk_timer_dp
  import convclk_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tmr_strobe_t         strb,
  input  logic [PERIOD_W-1:0] perData,
  output logic                tmrEvent,
  output logic [PERIOD_W-1:0] periodQ
);
  localparam logic [PERIOD_W-1:0] ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};

  logic [PERIOD_W-1:0] cnt;
  logic                armed;
  logic                hit;

  assign armed    = (periodQ != '0);
  assign hit      = armed && (cnt == periodQ - ONE);
  assign tmrEvent = strb.tmrAdv & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            periodQ <= '0;
    else if (strb.perLoad) periodQ <= perData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (strb.tmrClr)           cnt <= '0;
    else if (strb.tmrAdv && armed)  cnt <= hit ? '0 : cnt + ONE;
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.tmrClr |=> (cnt == '0));

  assert_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.tmrClr |=> $stable(periodQ));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (periodQ == '0) |-> (cnt == '0));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmrEvent |=> (cnt == '0));

  assert_cnt_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt < periodQ));
endmodule

// File: rtl/convclk_top.sv
module convclk_top
  import convclk_pkg::*;
#(
  parameter int SRC_W    = 3,
  parameter int CORE_W   = 1,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blkEnable,
  input  logic                cfgWr,
  input  logic [SRC_W-1:0]    cfgSrcDiv,
  input  logic [CORE_W-1:0]   cfgCoreDiv,
  input  logic                tmrEnable,
  input  logic                perWr,
  input  logic [PERIOD_W-1:0] perData,
  output logic                srcTick,
  output logic                coreTick,
  output logic                tmrEvent,
  output logic [SRC_W-1:0]    srcDivSet,
  output logic [CORE_W-1:0]   coreDivSet,
  output logic [PERIOD_W-1:0] periodSet
);
  tmr_strobe_t strb;

  convclk_ctrl #(.SRC_W(SRC_W), .CORE_W(CORE_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .blkEnable(blkEnable), .cfgWr(cfgWr),
    .cfgSrcDiv(cfgSrcDiv), .cfgCoreDiv(cfgCoreDiv), .tmrEnable(tmrEnable),
    .perWr(perWr), .srcTick(srcTick), .coreTick(coreTick),
    .srcDivQ(srcDivSet), .coreDivQ(coreDivSet), .strb(strb)
  );

  convclk_timer_dp #(.PERIOD_W(PERIOD_W)) uTmr (
    .clk(clk), .rst_n(rst_n), .strb(strb), .perData(perData),
    .tmrEvent(tmrEvent), .periodQ(periodSet)
  );

  // event only alongside a source strobe
  assert_evt_on_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmrEvent |-> srcTick);
endmodule

// File: tb/sim_convclk_top.sv
`timescale 1ns/1ps
module sim_convclk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blkEnable = 1'b0, cfgWr = 1'b0, cfgCoreDiv = 1'b0;
  logic tmrEnable = 1'b0, perWr = 1'b0;
  logic [2:0]  cfgSrcDiv = '0;
  logic [15:0] perData = '0;
  logic srcTick, coreTick, tmrEvent, coreDivSet;
  logic [2:0]  srcDivSet;
  logic [15:0] periodSet;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  longint enCnt = 0, srcCnt = 0, tmrTicks = 0;
  int mSrc = 0, mCore = 0, mPer = 0;

  always #10 clk = ~clk;

  convclk_top u0 (
    .clk(clk), .rst_n(rst_n), .blkEnable(blkEnable), .cfgWr(cfgWr),
    .cfgSrcDiv(cfgSrcDiv), .cfgCoreDiv(cfgCoreDiv), .tmrEnable(tmrEnable),
    .perWr(perWr), .perData(perData), .srcTick(srcTick), .coreTick(coreTick),
    .tmrEvent(tmrEvent), .srcDivSet(srcDivSet), .coreDivSet(coreDivSet),
    .periodSet(periodSet)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic bit expSrc();
    return blkEnable && ((enCnt % (mSrc + 1)) == mSrc);
  endfunction

  function automatic bit expCore(bit s);
    return s && (mCore == 0 || (srcCnt % 2) == 1);
  endfunction

  function automatic bit expEvt(bit s);
    return s && tmrEnable && mPer != 0 && (((tmrTicks + 1) % mPer) == 0);
  endfunction

  // compare at falling edge, then advance the model to the coming edge
  task automatic cycle();
    bit s, c, e;
    @(negedge clk);
    s = expSrc(); c = expCore(s); e = expEvt(s);
    chk("R1 R4 srcTick", srcTick, s);
    chk("R2 coreTick", coreTick, c);
    chk("R6 R8 R9 tmrEvent", tmrEvent, e);
    if (coreTick) chk("R3 coreTick without srcTick", srcTick, 1);
    if (tmrEvent) chk("R7 event without srcTick", srcTick, 1);
    chk("R5 srcDivSet", srcDivSet, mSrc);
    chk("R5 coreDivSet", coreDivSet, mCore);
    chk("R10 periodSet", periodSet, mPer);
    if (blkEnable) begin
      enCnt++;
      if (s) srcCnt++;
    end else begin
      enCnt = 0; srcCnt = 0;
    end
    if (tmrEnable) begin
      if (s) tmrTicks++;
    end else tmrTicks = 0;
    if (cfgWr && !blkEnable) begin mSrc = cfgSrcDiv; mCore = cfgCoreDiv; end
    if (perWr && !tmrEnable) mPer = perData;
    @(posedge clk); #1;
    cfgWr = 1'b0; perWr = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 srcTick", srcTick, 0);
    chk("R11 coreTick", coreTick, 0);
    chk("R11 tmrEvent", tmrEvent, 0);
    chk("R11 srcDivSet", srcDivSet, 0);
    chk("R11 coreDivSet", coreDivSet, 0);
    chk("R11 periodSet", periodSet, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run(2);

    // R1 divide by 1, R8 period zero with timer running
    blkEnable = 1; tmrEnable = 1; run(20);

    // R5 write ignored while enabled
    cfgWr = 1; cfgSrcDiv = 3'd5; cfgCoreDiv = 1; run(6);

    // R5 load while disabled, R4 restart
    blkEnable = 0; tmrEnable = 0; cfgWr = 1; cfgSrcDiv = 3'd2; cfgCoreDiv = 1; run(2);
    // R10 period load while timer off
    perWr = 1; perData = 16'd3; run(1);
    blkEnable = 1; tmrEnable = 1; run(40);
    // R10 write ignored while timer on
    perWr = 1; perData = 16'd7; run(20);
    // R9 clear on disable, full period after re-enable
    tmrEnable = 0; run(3); tmrEnable = 1; run(30);

    // boundary: largest source divisor, period 1
    blkEnable = 0; tmrEnable = 0; cfgWr = 1; cfgSrcDiv = 3'd7; cfgCoreDiv = 0; run(1);
    perWr = 1; perData = 16'd1; run(1);
    blkEnable = 1; tmrEnable = 1; run(50);
    // block disabled while timer on: count held
    blkEnable = 0; run(5); blkEnable = 1; run(30);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) blkEnable = ~blkEnable;
      if ($urandom % 30 == 0) tmrEnable = ~tmrEnable;
      if ($urandom % 8 == 0) begin
        cfgWr = 1; cfgSrcDiv = 3'($urandom); cfgCoreDiv = 1'($urandom);
      end
      if ($urandom % 8 == 0) begin
        perWr = 1; perData = 16'($urandom % 12);
      end
      cycle();
    end
    finishRun();
  end
endmodule